// File: doc/BRIEF.md
# Oversampled Phase Step Filter and Selector

This block sits behind a vote stage in a three-times-oversampling receiver. Once per reference clock period the vote stage presents a strobe together with an "early" and a "late" decision. The block passes a phase correction on only when the same direction has been voted several times in a row, and it keeps an index that names which of the oversampling phases is the current reference. When a filtered early vote arrives, the index moves to an earlier phase. When a filtered late vote arrives, the index moves to a later phase. The index wraps around the full ring of phases.

On every strobe the block also recovers one data word from the oversampled sample word. Each recovered bit is the centre sample of the three samples that belong to it, counted from the current reference phase. A lock flag reports that the loop has gone a set number of strobes without a correction.

Vote strobes are the only events that advance the block. Cycles without a strobe leave every piece of state untouched. The phase multiplexer and the clock generator that produce the samples are outside the block.

Top module: `phase_step_filter`

## Requirements
- R1: While reset is active, phase_sel is 0, locked is 0 and data_out is 0.
- R2: A vote is counted only on a cycle with vote_valid high. After three consecutive counted votes with vote_up=1 and vote_down=0, phase_sel decreases by one (toward earlier phases), visible from the clock edge that accepts the third vote. Two such votes leave phase_sel unchanged.
- R3: After three consecutive counted votes with vote_down=1 and vote_up=0, phase_sel increases by one (toward later phases).
- R4: A counted vote with neither bit set, with the opposite direction, or with both bits set clears the run for that direction. In each of these cases two votes before the interruption plus two votes after it produce no step.
- R5: Issuing a step clears that direction's run. Six consecutive early votes therefore produce exactly two steps, one at the third vote and one at the sixth.
- R6: phase_sel always stays in 0..20 and wraps modulo 21. An early step from 0 gives 20, and a late step from 20 gives 0.
- R7: On each counted cycle, data_out[k] for k in 0..6 is loaded with samples[(P + 3k + 1) mod 21], where P is the phase_sel value before that edge.
- R8: locked goes high once 16 consecutive counted votes have produced no step. It goes low at the same edge that applies a step.
- R9: Cycles with vote_valid low do not change phase_sel, data_out, locked or any vote run, whatever vote_up, vote_down and samples carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vote_valid | input | 1 | Strobe marking a vote cycle |
| vote_up | input | 1 | Vote that sampling should move earlier |
| vote_down | input | 1 | Vote that sampling should move later |
| samples | input | 21 | Oversampled word, three samples per data bit |
| phase_sel | output | 5 | Index of the reference sampling phase, 0..20 |
| data_out | output | 7 | Recovered word, centre sample of each bit |
| locked | output | 1 | High after a run of votes without a step |

## Verification
The bench builds the block with its default parameters: seven bits, three samples per bit, a run length of three votes and a lock window of 16. These values put both wrap points of the 21-phase ring within a handful of votes. The lock window can be filled and broken within a few dozen cycles, so runs, interruptions, the lock window and both wrap directions can each be driven explicitly. A behavioural model keeps plain integer run and quiet counters, and the bench compares it against the outputs on every clock while random sample words are applied.

// File: rtl/phase_step_filter.sv
module phase_step_filter #(
  parameter int NBITS       = 7,
  parameter int OVS         = 3,
  parameter int VOTES       = 3,
  parameter int LOCK_CYCLES = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               vote_valid,
  input  logic                               vote_up,
  input  logic                               vote_down,
  input  logic [NBITS*OVS-1:0]               samples,
  output logic [$clog2(NBITS*OVS)-1:0]       phase_sel,
  output logic [NBITS-1:0]                   data_out,
  output logic                               locked
);
  localparam int NPH = NBITS * OVS;
  localparam int PW  = $clog2(NPH);
  localparam int VW  = $clog2(VOTES + 1);
  localparam int LW  = $clog2(LOCK_CYCLES + 1);
  localparam int MID = OVS / 2;
  localparam logic [PW-1:0] PH_LAST  = PW'(NPH - 1);
  localparam logic [VW-1:0] RUN_LAST = VW'(VOTES - 1);
  localparam logic [LW-1:0] QUIET_MAX = LW'(LOCK_CYCLES);

  logic [VW-1:0] up_run, dn_run;
  logic [LW-1:0] quiet;
  logic [NBITS-1:0] centre;

  wire up_only = vote_up & ~vote_down;
  wire dn_only = vote_down & ~vote_up;
  wire step_up = vote_valid & up_only & (up_run == RUN_LAST);
  wire step_dn = vote_valid & dn_only & (dn_run == RUN_LAST);
  wire step    = step_up | step_dn;

  assign locked = (quiet == QUIET_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_run <= '0;
      dn_run <= '0;
    end else if (vote_valid) begin
      up_run <= (up_only && !step_up) ? up_run + VW'(1) : '0;
      dn_run <= (dn_only && !step_dn) ? dn_run + VW'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_sel <= '0;
    else if (step_up)
      phase_sel <= (phase_sel == '0) ? PH_LAST : phase_sel - PW'(1);
    else if (step_dn)
      phase_sel <= (phase_sel == PH_LAST) ? '0 : phase_sel + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet <= '0;
    else if (vote_valid) begin
      if (step)
        quiet <= '0;
      else if (!locked)
        quiet <= quiet + LW'(1);
    end
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_centre
    logic [PW:0] sum, pick;
    assign sum  = {1'b0, phase_sel} + (PW+1)'(k * OVS + MID);
    assign pick = (sum >= (PW+1)'(NPH)) ? sum - (PW+1)'(NPH) : sum;
    assign centre[k] = samples[pick[PW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_out <= '0;
    else if (vote_valid)
      data_out <= centre;
  end
endmodule

// File: rtl/phase_step_filter_chk.sv
module phase_step_filter_chk #(
  parameter int NBITS = 7,
  parameter int OVS   = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          vote_valid,
  input logic                          vote_up,
  input logic                          vote_down,
  input logic [NBITS*OVS-1:0]          samples,
  input logic [$clog2(NBITS*OVS)-1:0]  phase_sel,
  input logic [NBITS-1:0]              data_out,
  input logic                          locked
);
  localparam int PW = $clog2(NBITS*OVS);
  localparam logic [PW-1:0] LAST = PW'(NBITS*OVS - 1);

  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_sel <= LAST);

  p_step_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_sel) |-> ($past(vote_valid) && ($past(vote_up) != $past(vote_down))));

  p_up_earlier_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(phase_sel) && $past(vote_up)) |->
      phase_sel == (($past(phase_sel) == '0) ? LAST : $past(phase_sel) - PW'(1)));

  p_down_later_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(phase_sel) && $past(vote_down)) |->
      phase_sel == (($past(phase_sel) == LAST) ? '0 : $past(phase_sel) + PW'(1)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_valid |=> ($stable(phase_sel) && $stable(data_out) && $stable(locked)));

  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_sel) |-> !locked);
endmodule

bind phase_step_filter phase_step_filter_chk #(.NBITS(NBITS), .OVS(OVS)) u_chk (.*);

// File: tb/phase_step_filter_bench.sv
module phase_step_filter_bench;
  localparam int NB = 7;
  localparam int NP = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vote_valid = 1'b0, vote_up = 1'b0, vote_down = 1'b0;
  logic [NP-1:0] samples = '0;
  logic [4:0] phase_sel;
  logic [NB-1:0] data_out;
  logic locked;

  int n_checks = 0, n_fail = 0;
  int m_phase = 0, m_up = 0, m_dn = 0, m_quiet = 0;
  logic [NB-1:0] m_data = '0;

  always #5 clk = ~clk;

  phase_step_filter u_phase_step_filter (
    .clk(clk), .rst_n(rst_n), .vote_valid(vote_valid), .vote_up(vote_up),
    .vote_down(vote_down), .samples(samples), .phase_sel(phase_sel),
    .data_out(data_out), .locked(locked));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_up = 0; m_dn = 0; m_quiet = 0; m_data = '0;
    end else if (vote_valid) begin
      bit stepped;
      stepped = 1'b0;
      for (int k = 0; k < NB; k++) m_data[k] = samples[(m_phase + 3*k + 1) % NP];
      if (vote_up && !vote_down) begin
        m_dn = 0; m_up++;
        if (m_up == 3) begin m_up = 0; m_phase = (m_phase + NP - 1) % NP; stepped = 1'b1; end
      end else if (vote_down && !vote_up) begin
        m_up = 0; m_dn++;
        if (m_dn == 3) begin m_dn = 0; m_phase = (m_phase + 1) % NP; stepped = 1'b1; end
      end else begin
        m_up = 0; m_dn = 0;
      end
      if (stepped) m_quiet = 0;
      else if (m_quiet < 16) m_quiet++;
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2/R3/R6 phase model", phase_sel, m_phase);
    check("R7 data model", data_out, m_data);
    check("R8 lock model", locked, m_quiet == 16);
  end

  task automatic vote(bit v, bit u, bit d);
    @(negedge clk); #1;
    vote_valid = v; vote_up = u; vote_down = d; samples = NP'($urandom);
    @(posedge clk); #1;
    vote_valid = 1'b0; vote_up = 1'b0; vote_down = 1'b0;
  endtask

  task automatic votes(int n, bit u, bit d);
    for (int i = 0; i < n; i++) vote(1'b1, u, d);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NB-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset phase", phase_sel, 0);
    check("R1 reset lock", locked, 0);
    check("R1 reset data", data_out, 0);
    @(negedge clk); rst_n = 1'b1;

    votes(2, 1, 0); @(negedge clk);
    check("R2 two ups no step", phase_sel, 0);
    vote(1, 1, 0); @(negedge clk);
    check("R2 R6 third up wraps 0 to 20", phase_sel, 20);
    votes(3, 0, 1); @(negedge clk);
    check("R3 R6 three downs wrap 20 to 0", phase_sel, 0);

    votes(2, 1, 0); vote(1, 0, 0); votes(2, 1, 0); @(negedge clk);
    check("R4 idle vote breaks run", phase_sel, 0);
    vote(1, 0, 0);
    votes(2, 1, 0); vote(1, 0, 1); votes(2, 1, 0); @(negedge clk);
    check("R4 opposite vote breaks run", phase_sel, 0);
    vote(1, 0, 0);
    votes(2, 1, 0); vote(1, 1, 1); votes(2, 1, 0); @(negedge clk);
    check("R4 both-high vote breaks run", phase_sel, 0);
    vote(1, 0, 0);

    votes(3, 1, 0); @(negedge clk);
    check("R5 first step", phase_sel, 20);
    votes(3, 1, 0); @(negedge clk);
    check("R5 second step after cleared run", phase_sel, 19);

    votes(2, 1, 0); @(negedge clk);
    held = data_out;
    for (int i = 0; i < 5; i++) vote(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R9 invalid ups do not step", phase_sel, 19);
    check("R9 data held on invalid cycles", data_out, held);
    vote(1, 1, 0); @(negedge clk);
    check("R9 run survives invalid gap", phase_sel, 18);

    votes(15, 0, 0); @(negedge clk);
    check("R8 not locked after 15 quiet", locked, 0);
    vote(1, 0, 0); @(negedge clk);
    check("R8 locked after 16 quiet", locked, 1);
    votes(2, 0, 1); @(negedge clk);
    check("R8 still locked before step", locked, 1);
    vote(1, 0, 1); @(negedge clk);
    check("R8 step drops lock", locked, 0);
    check("R3 step to later phase", phase_sel, 19);

    @(negedge clk); #1;
    vote_valid = 1'b1; samples = NP'(1) << ((19 + 3*3 + 1) % NP);
    @(posedge clk); #1; vote_valid = 1'b0;
    @(negedge clk);
    check("R7 centre sample of bit 3", data_out, 7'h08);
    check("R7 no step on idle vote", phase_sel, 19);

    votes(40, 0, 0);
    finish_run();
  end
endmodule